// File: doc/BRIEF.md
# TDD symbol direction pattern generator

This block answers, for any slot and symbol of a radio frame, whether that symbol is used for downlink, uplink or guard in a time-division duplex pattern. Its static configuration has five fields. The numerology sets the slot count per frame. A count of pattern periods per frame sets the period length in slots. The remaining three fields are the number of leading full-downlink slots in each period and the downlink and uplink symbol counts of the single mixed slot that follows them. Every slot after the mixed slot, up to the end of the period, is uplink. The pattern then starts again with the next period.

Queries arrive on a valid/ready stream that carries a slot index and a symbol index. Answers leave on a second valid/ready stream as a 2-bit code, one registered answer per accepted query. A query is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high when the output register is empty or when its content is taken in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the answer stays unchanged and no new query is accepted.

The geometry outputs are combinational, and so is the configuration error flag. Together they give the slot count per frame and per period.

Top module: `tdd_dir_gen`

## Requirements
- R1: `slots_per_frame` equals 10·2^`cfg_mu` when `cfg_mu` ≤ MAX_MU (4), and 0 otherwise.
- R2: `slots_per_period` equals `slots_per_frame` / `cfg_nper`, or 0 when `cfg_nper` is 0.
- R3: `cfg_err` is 1 in any of these cases: `cfg_dl_sym`+`cfg_ul_sym` > 14; `cfg_dl_slots` ≥ `slots_per_period`; `cfg_nper` is 0; `cfg_mu` > MAX_MU; `cfg_nper` does not divide `slots_per_frame`. Otherwise it is 0.
- R4: A slot whose position p = slot mod `slots_per_period` is below `cfg_dl_slots` gives code 0 (downlink) on all 14 symbols.
- R5: At position p = `cfg_dl_slots` (the mixed slot), symbols below `cfg_dl_sym` give 0. Symbols at or above 14−`cfg_ul_sym` give 1 (uplink). The symbols in between give 2 (guard).
- R6: Positions above `cfg_dl_slots` give code 1 on all symbols.
- R7: The pattern repeats every `slots_per_period` slots across the frame.
- R8: Code 3 is returned when `cfg_err` is 1, when the symbol index is 14 or more, or when the slot index is `slots_per_frame` or more.
- R9: An answer appears on `out_valid`/`out_dir` at the clock edge that accepts its query, so it is visible one cycle after the query is presented.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_dir` holds its value. `in_ready` equals NOT `out_valid` OR `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mu | input | 3 | Numerology |
| cfg_nper | input | 5 | Pattern periods per frame |
| cfg_dl_slots | input | 8 | Full-downlink slots per period |
| cfg_dl_sym | input | 4 | Downlink symbols at the start of the mixed slot |
| cfg_ul_sym | input | 4 | Uplink symbols at the end of the mixed slot |
| cfg_err | output | 1 | Configuration rejected |
| slots_per_frame | output | 8 | Slot count per frame |
| slots_per_period | output | 8 | Slot count per pattern period |
| in_valid | input | 1 | Query valid |
| in_ready | output | 1 | Query can be accepted |
| in_slot | input | 8 | Slot index in frame |
| in_sym | input | 4 | Symbol index in slot |
| out_valid | output | 1 | Answer valid |
| out_ready | input | 1 | Downstream takes the answer |
| out_dir | output | 2 | Code: 0 downlink, 1 uplink, 2 guard, 3 invalid |

## Verification
The geometry outputs and `cfg_err` are combinational. The bench checks them in the same cycle in which the configuration is applied, sampling at the falling edge. A direction code is due at the rising edge that accepts its query. The bench presents each query at a falling edge and checks `out_valid` and `out_dir` at the next falling edge. For back-pressure, the bench holds `out_ready` low over several edges and checks at each falling edge that `in_ready` stays low and the first answer does not change.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
  localparam int SYMS_PER_SLOT = 14;
  typedef enum logic [1:0] {
    DIR_DL    = 2'd0,
    DIR_UL    = 2'd1,
    DIR_GUARD = 2'd2,
    DIR_BAD   = 2'd3
  } dir_e;
endpackage

// File: rtl/tdd_geom.sv
module tdd_geom #(
  parameter int MAX_MU = 4,
  parameter int SLOT_W = 8,
  parameter int MU_W   = 3,
  parameter int NPER_W = 5,
  parameter int SYM_W  = 4
) (
  input  logic [MU_W-1:0]   mu,
  input  logic [NPER_W-1:0] nper,
  input  logic [SLOT_W-1:0] dl_slots,
  input  logic [SYM_W-1:0]  dl_sym,
  input  logic [SYM_W-1:0]  ul_sym,
  output logic [SLOT_W-1:0] spf,
  output logic [SLOT_W-1:0] spp,
  output logic              err
);
  import tdd_pkg::*;
  localparam logic [SYM_W:0] SYM_LIMIT = (SYM_W+1)'(SYMS_PER_SLOT);

  logic              mu_ok;
  logic [SLOT_W-1:0] nper_ext;
  logic [SLOT_W-1:0] rem;
  logic [SYM_W:0]    sym_sum;

  assign mu_ok    = (int'(mu) <= MAX_MU);
  assign spf      = mu_ok ? (SLOT_W'(10) << mu) : '0;
  assign nper_ext = SLOT_W'(nper);
  assign spp      = (nper_ext != '0) ? (spf / nper_ext) : '0;
  assign rem      = (nper_ext != '0) ? (spf % nper_ext) : '0;
  assign sym_sum  = {1'b0, dl_sym} + {1'b0, ul_sym};
  assign err      = !mu_ok || (nper_ext == '0) || (rem != '0) ||
                    (sym_sum > SYM_LIMIT) || (dl_slots >= spp);

  // R3
  always_comb begin
    if (!err)
      no_partial_period_chk: assert ((spp * nper_ext) == spf);
  end
endmodule

// File: rtl/tdd_classify.sv
module tdd_classify #(
  parameter int SLOT_W = 8,
  parameter int SYM_W  = 4
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [SYM_W-1:0]  sym,
  input  logic [SLOT_W-1:0] spf,
  input  logic [SLOT_W-1:0] spp,
  input  logic              err,
  input  logic [SLOT_W-1:0] dl_slots,
  input  logic [SYM_W-1:0]  dl_sym,
  input  logic [SYM_W-1:0]  ul_sym,
  output tdd_pkg::dir_e     code
);
  import tdd_pkg::*;
  localparam logic [SYM_W:0] SYM_LIMIT = (SYM_W+1)'(SYMS_PER_SLOT);

  logic [SLOT_W-1:0] pos;
  logic [SYM_W:0]    sym_ext;
  logic [SYM_W:0]    ul_start;

  assign pos      = (spp != '0) ? (slot % spp) : '0;
  assign sym_ext  = {1'b0, sym};
  assign ul_start = SYM_LIMIT - {1'b0, ul_sym};

  always_comb begin
    if (err || (sym_ext >= SYM_LIMIT) || (slot >= spf))
      code = DIR_BAD;
    else if (pos < dl_slots)
      code = DIR_DL;
    else if (pos == dl_slots) begin
      if (sym < dl_sym)             code = DIR_DL;
      else if (sym_ext >= ul_start) code = DIR_UL;
      else                          code = DIR_GUARD;
    end else
      code = DIR_UL;
  end
endmodule

// File: rtl/tdd_dir_gen.sv
module tdd_dir_gen #(
  parameter int MAX_MU = 4,
  parameter int MU_W   = 3,
  parameter int NPER_W = 5,
  parameter int SYM_W  = 4,
  parameter int SLOT_W = $clog2(10 * (1 << MAX_MU) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MU_W-1:0]   cfg_mu,
  input  logic [NPER_W-1:0] cfg_nper,
  input  logic [SLOT_W-1:0] cfg_dl_slots,
  input  logic [SYM_W-1:0]  cfg_dl_sym,
  input  logic [SYM_W-1:0]  cfg_ul_sym,
  output logic              cfg_err,
  output logic [SLOT_W-1:0] slots_per_frame,
  output logic [SLOT_W-1:0] slots_per_period,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [SYM_W-1:0]  in_sym,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_dir
);
  import tdd_pkg::*;

  dir_e code;

  tdd_geom #(.MAX_MU(MAX_MU), .SLOT_W(SLOT_W), .MU_W(MU_W),
             .NPER_W(NPER_W), .SYM_W(SYM_W)) u_geom (
    .mu(cfg_mu), .nper(cfg_nper), .dl_slots(cfg_dl_slots),
    .dl_sym(cfg_dl_sym), .ul_sym(cfg_ul_sym),
    .spf(slots_per_frame), .spp(slots_per_period), .err(cfg_err)
  );

  tdd_classify #(.SLOT_W(SLOT_W), .SYM_W(SYM_W)) u_cls (
    .slot(in_slot), .sym(in_sym), .spf(slots_per_frame),
    .spp(slots_per_period), .err(cfg_err), .dl_slots(cfg_dl_slots),
    .dl_sym(cfg_dl_sym), .ul_sym(cfg_ul_sym), .code(code)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dir   <= 2'd0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_dir <= code;
    end
  end

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dir)));

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  bad_symbol_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (int'(in_sym) >= SYMS_PER_SLOT)) |=> (out_dir == 2'd3));
endmodule

// File: tb/tb_tdd_dir_gen.sv
module tb_tdd_dir_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] cfg_mu = 0;
  logic [4:0] cfg_nper = 1;
  logic [7:0] cfg_dl_slots = 0;
  logic [3:0] cfg_dl_sym = 0, cfg_ul_sym = 0;
  logic cfg_err;
  logic [7:0] slots_per_frame, slots_per_period;
  logic in_valid = 0, in_ready;
  logic [7:0] in_slot = 0;
  logic [3:0] in_sym = 0;
  logic out_valid;
  logic out_ready = 1;
  logic [1:0] out_dir;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tdd_dir_gen dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_spf(int mu);
    return (mu <= 4) ? 10 * (1 << mu) : 0;
  endfunction

  function automatic int exp_spp(int mu, int np);
    return (np == 0) ? 0 : exp_spf(mu) / np;
  endfunction

  function automatic int exp_err(int mu, int np, int dls, int a, int b);
    int f = exp_spf(mu);
    if (mu > 4 || np == 0) return 1;
    if (f % np != 0) return 1;
    if (a + b > 14) return 1;
    if (dls >= f / np) return 1;
    return 0;
  endfunction

  function automatic int exp_code(int mu, int np, int dls, int a, int b, int s, int y);
    int p;
    if (exp_err(mu, np, dls, a, b) != 0 || y >= 14 || s >= exp_spf(mu)) return 3;
    p = s % exp_spp(mu, np);
    if (p < dls) return 0;
    if (p > dls) return 1;
    if (y < a) return 0;
    if (y >= 14 - b) return 1;
    return 2;
  endfunction

  task automatic set_cfg(int mu, int np, int dls, int a, int b);
    @(negedge clk);
    cfg_mu = 3'(mu); cfg_nper = 5'(np); cfg_dl_slots = 8'(dls);
    cfg_dl_sym = 4'(a); cfg_ul_sym = 4'(b);
    #1;
    chk("R1 slots_per_frame", int'(slots_per_frame), exp_spf(mu));
    chk("R2 slots_per_period", int'(slots_per_period), exp_spp(mu, np));
    chk("R3 cfg_err", int'(cfg_err), exp_err(mu, np, dls, a, b));
  endtask

  task automatic query(int s, int y, int e, string req);
    @(negedge clk);
    in_valid = 1; in_slot = 8'(s); in_sym = 4'(y);
    @(negedge clk);
    in_valid = 0;
    chk({req, " out_valid R9"}, int'(out_valid), 1);
    chk(req, int'(out_dir), e);
  endtask

  task automatic sweep(int mu, int np, int dls, int a, int b, int extra);
    int f = exp_spf(mu);
    set_cfg(mu, np, dls, a, b);
    for (int s = 0; s < f + extra; s++)
      for (int y = 0; y < 16; y++) begin
        int e = exp_code(mu, np, dls, a, b, s, y);
        string r;
        if (e == 3) r = "R8";
        else if (s % exp_spp(mu, np) < dls) r = "R4";
        else if (s % exp_spp(mu, np) == dls) r = "R5";
        else r = "R6";
        if (s >= exp_spp(mu, np) && e != 3) r = {r, " R7"};
        query(s, y, e, r);
      end
  endtask

  initial begin
    #5;
    chk("reset out_valid", int'(out_valid), 0);
    chk("reset in_ready R10", int'(in_ready), 1);
    repeat (2) @(negedge clk);
    rst_n = 1;

    sweep(1, 2, 3, 7, 3, 2);   // period 10, guard 4 symbols
    sweep(0, 1, 7, 10, 4, 1);  // no guard
    sweep(2, 8, 2, 0, 0, 1);   // mixed slot all guard, period 5
    sweep(0, 2, 0, 14, 0, 0);  // mixed slot all downlink

    // R3 / R8 rejections
    set_cfg(1, 2, 3, 9, 6);  query(0, 0, 3, "R8 sum>14");
    set_cfg(1, 2, 10, 2, 2); query(0, 0, 3, "R8 dl_slots>=period");
    set_cfg(1, 3, 1, 2, 2);  query(0, 0, 3, "R8 nondividing");
    set_cfg(1, 0, 0, 2, 2);  query(0, 0, 3, "R8 nper zero");
    set_cfg(5, 1, 0, 2, 2);  query(0, 0, 3, "R8 mu too big");
    set_cfg(4, 16, 3, 2, 2); query(159, 13, 1, "R6 max frame");

    // R10 back-pressure
    set_cfg(1, 2, 3, 7, 3);
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_slot = 0; in_sym = 0;
    @(negedge clk);
    chk("R9 valid under stall", int'(out_valid), 1);
    chk("R10 in_ready low", int'(in_ready), 0);
    chk("R10 first answer", int'(out_dir), 0);
    in_slot = 9; in_sym = 5;
    repeat (3) @(negedge clk);
    chk("R10 held answer", int'(out_dir), 0);
    chk("R10 still stalled", int'(in_ready), 0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R10 second answer", int'(out_dir), 1);
    @(negedge clk);
    chk("R10 drained", int'(out_valid), 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule